// File: doc/BRIEF.md
# Keyed Configuration Port Front End

This block is the configuration-space front end of a peripheral-controller chip. Software reaches it through two byte-wide I/O ports: an index port and a data port. After reset the configuration space is closed. Reads of either port return 0xFF, and writes to the data port do nothing.

Software opens the space by writing a fixed four-byte key to the index port. It then writes a register number to the index port and reads or writes that register through the data port. A logical-device selector register picks which device's bank of registers answers at the device-specific indices. Read-only identification and revision registers sit in the global space. An exit command written through the data port closes the space again.

Top module: `sio_cfg_port`

## Requirements
- R1: A synchronous active-low reset leaves the space closed and clears the latched index, the device selector and every device register to 0x00.
- R2: While the space is closed, a read of the index port (0x2E) or the data port (0x2F) returns 0xFF.
- R3: Writing 0x87, 0x01, 0x55, 0x55 to the index port, in that order, opens the space. The same bytes written to the data port do not open it.
- R4: While closed, a byte on the index port that breaks the key sequence restarts matching. If that byte is 0x87, it counts as the first key byte.
- R5: While open, an index-port write latches the index and an index-port read returns it. Index-port writes made while closed, including the key bytes, do not change the latched index.
- R6: Index 0x07 is a read/write device selector, 0x00 after reset. Indices 0x70 to 0x73 map to a separate set of four read/write registers for each selector value 0 to 7.
- R7: Index 0x20 reads the high byte of the 16-bit chip ID (default 0x8728) and index 0x21 reads its low byte. Writes to these indices have no effect.
- R8: Index 0x22 reads the revision in bits 3:0 (default 5) with bits 7:4 zero. Writes to it have no effect.
- R9: Writing 0x02 through the data port while the index is 0x02 closes the space. Any other value written at index 0x02 leaves it open.
- R10: Unimplemented indices read 0x00. When the selector is 8 or more, the device indices read 0x00 and writes to them are dropped.
- R11: The read data is 0xFF whenever no read strobe is active or the address matches neither port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe; read data is combinational |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data byte |

## Verification
The bench probes the key matcher with partial and broken keys. A matcher that fails to restart would open after a stray byte. One that drops a repeated 0x87 would stay closed after a valid retry. The bench also sends the key bytes to the data port, where a design with loose address decoding would open.

Bank isolation is checked by writing one device register under two selector values and reading each back, so a design that ignores the selector would return the last value written. An out-of-range selector is also used. The index is checked across a close and reopen: a design that latched key bytes as the index would return 0x55 instead of the preserved value. A non-exit value written at the exit index must not close the space.

// File: rtl/sio_cfg_pkg.sv
// Package: shared constants and access types for the keyed configuration port.
// Assumes byte-wide ports and 8-bit register indices.
package sio_cfg_pkg;

    localparam logic [7:0] IDX_EXIT    = 8'h02;
    localparam logic [7:0] EXIT_CODE   = 8'h02;
    localparam logic [7:0] IDX_DEVSEL  = 8'h07;
    localparam logic [7:0] IDX_ID_HI   = 8'h20;
    localparam logic [7:0] IDX_ID_LO   = 8'h21;
    localparam logic [7:0] IDX_REV     = 8'h22;
    localparam logic [7:0] CLOSED_READ = 8'hFF;

    // One decoded write cycle toward the configuration logic.
    typedef struct packed {
        logic       idx_wr;
        logic       dat_wr;
        logic [7:0] wdata;
    } cfg_wr_t;

endpackage

// File: rtl/sio_key_fsm.sv
// Module: key matcher and open/closed state.
// Watches index-port writes while closed and opens after the full key.
// Closes on the exit command from the register banks. Assumes KEY_LEN >= 2.
module sio_key_fsm
    import sio_cfg_pkg::*;
#(
    parameter int               KEY_LEN = 4,
    parameter logic [8*KEY_LEN-1:0] KEY = 32'h87015555
) (
    input  logic    clk,
    input  logic    rst_n,
    input  cfg_wr_t wr,
    input  logic    exit_cmd,
    output logic    unlocked
);
    localparam int         CW        = $clog2(KEY_LEN + 1);
    localparam logic [7:0] FIRST_KEY = KEY[8*KEY_LEN-1 -: 8];
    localparam logic [7:0] LAST_KEY  = KEY[7:0];

    logic [CW-1:0] match_cnt;
    logic [7:0]    expect_byte;

    // Select the key byte expected at the current match position.
    always_comb begin
        expect_byte = FIRST_KEY;
        for (int i = 0; i < KEY_LEN; i++) begin
            if (match_cnt == CW'(i)) expect_byte = KEY[8*(KEY_LEN-1-i) +: 8];
        end
    end

    // Advance, restart or complete key matching; close on the exit command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_cnt <= '0;
            unlocked  <= 1'b0;
        end else if (unlocked) begin
            match_cnt <= '0;
            if (exit_cmd) unlocked <= 1'b0;
        end else if (wr.idx_wr) begin
            if (wr.wdata == expect_byte) begin
                if (match_cnt == CW'(KEY_LEN - 1)) begin
                    unlocked  <= 1'b1;
                    match_cnt <= '0;
                end else begin
                    match_cnt <= match_cnt + CW'(1);
                end
            end else if (wr.wdata == FIRST_KEY) begin
                match_cnt <= CW'(1);
            end else begin
                match_cnt <= '0;
            end
        end
    end

    AST_OPEN_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(wr.idx_wr && wr.wdata == LAST_KEY)); // R3

    AST_CLOSE_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unlocked) |-> $past(exit_cmd)); // R9

endmodule

// File: rtl/sio_index_latch.sv
// Module: configuration index register.
// Captures index-port writes only while the space is open; holds otherwise.
module sio_index_latch
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cfg_wr_t    wr,
    input  logic       unlocked,
    output logic [7:0] idx_q
);
    // Latch the index on an open-state index write.
    always_ff @(posedge clk) begin
        if (!rst_n)                     idx_q <= 8'h00;
        else if (unlocked && wr.idx_wr) idx_q <= wr.wdata;
    end

    AST_INDEX_FROZEN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(idx_q)); // R5

endmodule

// File: rtl/sio_reg_banks.sv
// Module: global registers plus per-device register banks.
// The selector at IDX_DEVSEL picks the visible bank. Chip ID and revision
// are constants. Decodes the exit command for the key matcher.
module sio_reg_banks
    import sio_cfg_pkg::*;
#(
    parameter int          DEV_COUNT = 8,
    parameter int          DEV_REGS  = 4,
    parameter logic [7:0]  DEV_BASE  = 8'h70,
    parameter logic [15:0] CHIP_ID   = 16'h8728,
    parameter logic [3:0]  CHIP_REV  = 4'h5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  cfg_wr_t    wr,
    input  logic       unlocked,
    input  logic [7:0] idx,
    output logic [7:0] cfg_rdata,
    output logic       exit_cmd
);
    logic       dat_wr_open;
    logic [7:0] devsel_q;
    logic [7:0] dev_regs [DEV_COUNT][DEV_REGS];

    assign dat_wr_open = unlocked && wr.dat_wr;
    assign exit_cmd    = dat_wr_open && idx == IDX_EXIT && wr.wdata == EXIT_CODE;

    // Device selector register.
    always_ff @(posedge clk) begin
        if (!rst_n)                              devsel_q <= 8'h00;
        else if (dat_wr_open && idx == IDX_DEVSEL) devsel_q <= wr.wdata;
    end

    for (genvar l = 0; l < DEV_COUNT; l++) begin : g_dev
        for (genvar r = 0; r < DEV_REGS; r++) begin : g_reg
            // One device register, written when its bank is selected.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    dev_regs[l][r] <= 8'h00;
                else if (dat_wr_open && devsel_q == 8'(l) && idx == DEV_BASE + 8'(r))
                    dev_regs[l][r] <= wr.wdata;
            end
        end
    end

    // Read multiplexer over global and banked registers.
    always_comb begin
        cfg_rdata = 8'h00;
        case (idx)
            IDX_DEVSEL: cfg_rdata = devsel_q;
            IDX_ID_HI:  cfg_rdata = CHIP_ID[15:8];
            IDX_ID_LO:  cfg_rdata = CHIP_ID[7:0];
            IDX_REV:    cfg_rdata = {4'h0, CHIP_REV};
            default: begin
                for (int l = 0; l < DEV_COUNT; l++) begin
                    for (int r = 0; r < DEV_REGS; r++) begin
                        if (devsel_q == 8'(l) && idx == DEV_BASE + 8'(r))
                            cfg_rdata = dev_regs[l][r];
                    end
                end
            end
        endcase
    end

    AST_DEVSEL_HELD_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(devsel_q)); // R6

    AST_REV_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == IDX_REV) |-> cfg_rdata[7:4] == 4'h0); // R8

endmodule

// File: rtl/sio_cfg_port.sv
// Module: top of the keyed configuration port.
// Decodes the index and data port addresses and gates read data while closed.
// Assumes one-cycle write strobes and combinational reads.
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] INDEX_ADDR = 16'h002E,
    parameter logic [15:0] DATA_ADDR  = 16'h002F,
    parameter int          DEV_COUNT  = 8,
    parameter int          DEV_REGS   = 4,
    parameter logic [7:0]  DEV_BASE   = 8'h70,
    parameter logic [15:0] CHIP_ID    = 16'h8728,
    parameter logic [3:0]  CHIP_REV   = 4'h5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata
);
    logic       hit_idx, hit_dat, unlocked, exit_cmd;
    logic [7:0] idx_q, cfg_rdata;
    cfg_wr_t    wr;

    assign hit_idx   = io_addr == ADDR_W'(INDEX_ADDR);
    assign hit_dat   = io_addr == ADDR_W'(DATA_ADDR);
    assign wr.idx_wr = io_wr && hit_idx;
    assign wr.dat_wr = io_wr && hit_dat;
    assign wr.wdata  = io_wdata;

    sio_key_fsm u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr),
        .exit_cmd (exit_cmd),
        .unlocked (unlocked)
    );

    sio_index_latch u_idx (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr),
        .unlocked (unlocked),
        .idx_q    (idx_q)
    );

    sio_reg_banks #(
        .DEV_COUNT (DEV_COUNT),
        .DEV_REGS  (DEV_REGS),
        .DEV_BASE  (DEV_BASE),
        .CHIP_ID   (CHIP_ID),
        .CHIP_REV  (CHIP_REV)
    ) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr),
        .unlocked  (unlocked),
        .idx       (idx_q),
        .cfg_rdata (cfg_rdata),
        .exit_cmd  (exit_cmd)
    );

    // Port-level read data: 0xFF unless an open-state port read is active.
    always_comb begin
        io_rdata = CLOSED_READ;
        if (io_rd && unlocked) begin
            if (hit_idx)      io_rdata = idx_q;
            else if (hit_dat) io_rdata = cfg_rdata;
        end
    end

    AST_CLOSED_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && io_rd) |-> io_rdata == 8'hFF); // R2

    AST_IDLE_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_idx && !hit_dat) |-> io_rdata == 8'hFF); // R11

endmodule

// File: tb/tb_sio_cfg_port.sv
`timescale 1ns/1ps
// Bench: walks a vector table of port accesses, then runs directed reset and address tests.
module tb_sio_cfg_port;
    localparam logic [15:0] IA = 16'h002E;
    localparam logic [15:0] DA = 16'h002F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    int total = 0;
    int bad = 0;
    bit done = 0;

    sio_cfg_port dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    always #2.5 clk = ~clk;

    // Vector: {req nibble, op nibble, data byte, expected byte}
    // op 0 write index, 1 write data, 2 read index, 3 read data. req A means R10.
    localparam int NV = 64;
    localparam logic [23:0] VEC [NV] = '{
        24'h2300FF, 24'h2200FF,                                       // R2 closed reads
        24'h318700, 24'h310100, 24'h315500, 24'h315500, 24'h3300FF,   // R3 key on data port
        24'h408700, 24'h400100, 24'h403300, 24'h405500, 24'h405500,
        24'h4300FF,                                                   // R4 broken key
        24'h408700, 24'h408700, 24'h400100, 24'h405500, 24'h405500,   // R4 0x87 retry
        24'h520000, 24'h504000, 24'h520040,                           // R5 index latch
        24'hA30000,                                                   // R10 unimplemented
        24'h702000, 24'h730087, 24'h702100, 24'h730028,
        24'h71FF00, 24'h730028,                                       // R7 chip ID
        24'h802200, 24'h830005,                                       // R8 revision
        24'h600700, 24'h630000, 24'h610100, 24'h607000, 24'h61AA00,
        24'h600700, 24'h610200, 24'h607000, 24'h630000, 24'h615C00,
        24'h600700, 24'h610100, 24'h607000, 24'h6300AA,               // R6 banks
        24'hA00700, 24'hA10900, 24'hA30009, 24'hA07100, 24'hA13300,
        24'hA30000,                                                   // R10 selector out of range
        24'h900200, 24'h910100, 24'h920002,                           // R9 non-exit value
        24'h910200, 24'h9300FF, 24'h9200FF,                           // R9 exit
        24'h500700, 24'h508700, 24'h500100, 24'h505500, 24'h505500,
        24'h520002,                                                   // R5 index held while closed
        24'h600700, 24'h630009                                        // R6 selector held
    };

    task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d got=%02h expected=%02h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic wr_port(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd_port(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic unlock();
        wr_port(IA, 8'h87); wr_port(IA, 8'h01); wr_port(IA, 8'h55); wr_port(IA, 8'h55);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 / R11: output with no read strobe after reset
        #1 check(11, io_rdata, 8'hFF);

        for (int i = 0; i < NV; i++) begin
            logic [23:0] v;
            v = VEC[i];
            case (v[19:16])
                4'd0: wr_port(IA, v[15:8]);
                4'd1: wr_port(DA, v[15:8]);
                4'd2: begin rd_port(IA, r); check(int'(v[23:20]), r, v[7:0]); end
                default: begin rd_port(DA, r); check(int'(v[23:20]), r, v[7:0]); end
            endcase
        end

        // R11: open space, read an unrelated address
        wr_port(IA, 8'h70);
        rd_port(16'h0080, r); check(11, r, 8'hFF);
        rd_port(16'h002D, r); check(11, r, 8'hFF);
        // R11: data write to another address must not reach device register
        wr_port(IA, 8'h07); wr_port(DA, 8'h01); wr_port(IA, 8'h70);
        wr_port(16'h0030, 8'h11);
        rd_port(DA, r); check(11, r, 8'hAA);

        // R1: reset while open clears state and closes
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rd_port(DA, r); check(1, r, 8'hFF);
        rd_port(IA, r); check(1, r, 8'hFF);
        unlock();
        rd_port(IA, r); check(1, r, 8'h00);
        wr_port(IA, 8'h07);
        rd_port(DA, r); check(1, r, 8'h00);
        wr_port(DA, 8'h01); wr_port(IA, 8'h70);
        rd_port(DA, r); check(1, r, 8'h00);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule